// File: doc/BRIEF.md
# CAN FD Protocol Error Flag Register

This block keeps the sticky record of protocol errors that a CAN FD bit-stream engine reports. Each clock cycle the engine may raise strobes for bit, stuff, form, CRC and acknowledge errors. It also gives context signals: whether the fast data-rate phase is active, whether the transmitter delay compensation window is open, whether the stuff violation fell on a fixed stuff bit, and whether the CRC delimiter was corrupted. The block applies the CAN FD reclassification rules to these inputs. It then routes each error to a nominal-rate or fast-rate flag and latches it.

Software reads the 12-bit flag vector, zero-extended to the bus width, and writes ones to clear individual flags. Detecting errors on the bus, bit timing and raising interrupts are left to neighbouring blocks.

Top module: `canfd_err_status`

## Requirements
- R1: Flag positions: 0 CRC, 1 form, 2 stuff, 3 bit, 4 acknowledge; 8 fast CRC, 9 fast form, 10 fast stuff, 11 fast bit. Bits 5 to 7 and all bits above 11 always read 0.
- R2: While reset is high, every flag clears, and the read value is 0 after the reset edge.
- R3: A set flag stays 1 in every cycle that has no write of 1 to its position.
- R4: A write with wr_en high clears every flag whose wr_data bit is 1. Bits written as 0 keep their value.
- R5: Several errors in one cycle set every matching flag together.
- R6: With the fast indicator high and compensation inactive, bit, stuff, form and CRC errors set bits 11, 10, 9 and 8, and the nominal bits 3 to 0 stay untouched.
- R7: While the compensation indicator is high, any error strobe, acknowledge included, sets only bit 11.
- R8: A stuff error with the fixed-stuff indicator high sets the form flag of its rate group instead of the stuff flag.
- R9: A CRC error with the delimiter-corruption indicator high sets only the form flag of its rate group, and the CRC flag is left unchanged.
- R10: When an error event and a clearing write hit the same bit in one cycle, the bit ends up 1.
- R11: Outside compensation, an acknowledge error sets bit 4 in either rate phase.
- R12: An event or write presented before a rising clock edge shows on rd_data right after that edge. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bit | input | 1 | Bit error strobe |
| ev_stuff | input | 1 | Stuff error strobe |
| ev_form | input | 1 | Form error strobe |
| ev_crc | input | 1 | CRC error strobe |
| ev_ack | input | 1 | Acknowledge error strobe |
| in_fast | input | 1 | Data phase at fast rate is active |
| in_tdc | input | 1 | Transmitter delay compensation window is open |
| fixed_stuff | input | 1 | Current stuff bit is a fixed stuff bit |
| crc_delim_bad | input | 1 | CRC delimiter was corrupted |
| wr_en | input | 1 | Write strobe for clearing |
| wr_data | input | 12 | Write-one-to-clear mask |
| rd_data | output | DW (32) | Flag vector, zero-extended |

## Verification
A corrupted flag state shows on rd_data one edge after the event or write that caused it, because the read path is direct. A model comparison on every cycle therefore catches a lost, spurious or misrouted flag at the very next sample. A wrong routing rule appears as a bit in the wrong group, for example bit 2 in place of bit 9. It is caught in the cycle of the event and keeps showing until software clears the bit. A failed clear or a failed set-over-clear priority shows the same way, on the cycle that follows the write.

// File: rtl/canfd_err_pkg.sv
package canfd_err_pkg;

    localparam int FLAG_W = 12;

    localparam int B_CRC    = 0;
    localparam int B_FORM   = 1;
    localparam int B_STUFF  = 2;
    localparam int B_BIT    = 3;
    localparam int B_ACK    = 4;
    localparam int B_FCRC   = 8;
    localparam int B_FFORM  = 9;
    localparam int B_FSTUFF = 10;
    localparam int B_FBIT   = 11;

    localparam logic [FLAG_W-1:0] IMPL_MASK = 12'hF1F;

    typedef struct packed {
        logic bit_e;
        logic stuff_e;
        logic form_e;
        logic crc_e;
        logic ack_e;
    } err_evt_t;

    typedef struct packed {
        logic fast;
        logic tdc;
        logic fixed_stuff;
        logic crc_delim_bad;
    } err_ctx_t;

    typedef struct packed {
        logic bit_k;
        logic stuff_k;
        logic form_k;
        logic crc_k;
    } err_kind_t;

    typedef enum logic [1:0] {
        GRP_NOMINAL = 2'd0,
        GRP_FAST    = 2'd1,
        GRP_TDC     = 2'd2
    } err_grp_t;

    function automatic err_kind_t reclassify(err_evt_t e, err_ctx_t c);
        err_kind_t k;
        logic stuff_fixed;
        logic crc_delim;
        stuff_fixed = e.stuff_e & c.fixed_stuff;
        crc_delim   = e.crc_e & c.crc_delim_bad;
        k.bit_k   = e.bit_e;
        k.stuff_k = e.stuff_e & ~c.fixed_stuff;
        k.crc_k   = e.crc_e & ~c.crc_delim_bad;
        k.form_k  = e.form_e | stuff_fixed | crc_delim;
        return k;
    endfunction

    function automatic err_grp_t pick_group(err_ctx_t c);
        if (c.tdc)       return GRP_TDC;
        else if (c.fast) return GRP_FAST;
        else             return GRP_NOMINAL;
    endfunction

endpackage

// File: rtl/err_classify.sv
module err_classify
    import canfd_err_pkg::*;
(
    input  err_evt_t          evt,
    input  err_ctx_t          ctx,
    output logic [FLAG_W-1:0] set_vec
);
    err_kind_t kind;
    err_grp_t  grp;
    logic      any_evt;

    assign kind    = reclassify(evt, ctx);
    assign grp     = pick_group(ctx);
    assign any_evt = evt.bit_e | evt.stuff_e | evt.form_e | evt.crc_e | evt.ack_e;

    always_comb begin
        set_vec = '0;
        unique case (grp)
            GRP_TDC: begin
                set_vec[B_FBIT] = any_evt;
            end
            GRP_FAST: begin
                set_vec[B_FBIT]   = kind.bit_k;
                set_vec[B_FSTUFF] = kind.stuff_k;
                set_vec[B_FFORM]  = kind.form_k;
                set_vec[B_FCRC]   = kind.crc_k;
                set_vec[B_ACK]    = evt.ack_e;
            end
            default: begin
                set_vec[B_BIT]   = kind.bit_k;
                set_vec[B_STUFF] = kind.stuff_k;
                set_vec[B_FORM]  = kind.form_k;
                set_vec[B_CRC]   = kind.crc_k;
                set_vec[B_ACK]   = evt.ack_e;
            end
        endcase
    end
endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
    parameter int W = 12,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        logic nxt;
        assign nxt = (flags[i] & ~clr_vec[i]) | set_vec[i];
        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= MASK[i] ? nxt : 1'b0;
        end
    end
endmodule

// File: rtl/canfd_err_status.sv
module canfd_err_status
    import canfd_err_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_bit,
    input  logic              ev_stuff,
    input  logic              ev_form,
    input  logic              ev_crc,
    input  logic              ev_ack,
    input  logic              in_fast,
    input  logic              in_tdc,
    input  logic              fixed_stuff,
    input  logic              crc_delim_bad,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [DW-1:0]     rd_data
);
    localparam int PAD_W = DW - FLAG_W;

    err_evt_t          evt;
    err_ctx_t          ctx;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flags;

    assign evt = '{bit_e: ev_bit, stuff_e: ev_stuff, form_e: ev_form,
                   crc_e: ev_crc, ack_e: ev_ack};
    assign ctx = '{fast: in_fast, tdc: in_tdc, fixed_stuff: fixed_stuff,
                   crc_delim_bad: crc_delim_bad};
    assign clr_vec = wr_en ? wr_data : '0;

    err_classify u_classify (
        .evt     (evt),
        .ctx     (ctx),
        .set_vec (set_vec)
    );

    err_flag_bank #(.W(FLAG_W), .MASK(IMPL_MASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    assign rd_data = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/canfd_err_status_chk.sv
module canfd_err_status_chk
    import canfd_err_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_bit,
    input logic              ev_stuff,
    input logic              ev_form,
    input logic              ev_crc,
    input logic              ev_ack,
    input logic              in_fast,
    input logic              in_tdc,
    input logic              wr_en,
    input logic [FLAG_W-1:0] wr_data,
    input logic [DW-1:0]     rd_data
);
    logic any_ev;
    assign any_ev = ev_bit | ev_stuff | ev_form | ev_crc | ev_ack;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> rd_data == '0); // R2
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000 && (rd_data >> FLAG_W) == '0); // R1
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_data & $past(rd_data)) == $past(rd_data)); // R3
    AST_CLEAR_CRC: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_data[B_CRC] && !ev_crc |=> !rd_data[B_CRC]); // R4
    AST_FAST_BIT: assert property (@(posedge clk) disable iff (rst)
        in_fast && !in_tdc && ev_bit |=> rd_data[B_FBIT]); // R6
    AST_TDC_BIT: assert property (@(posedge clk) disable iff (rst)
        in_tdc && any_ev |=> rd_data[B_FBIT]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ev_ack && !in_tdc && wr_en && wr_data[B_ACK] |=> rd_data[B_ACK]); // R10
    AST_ACK_NOM: assert property (@(posedge clk) disable iff (rst)
        ev_ack && !in_tdc |=> rd_data[B_ACK]); // R11
endmodule

bind canfd_err_status canfd_err_status_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_bit   (ev_bit),
    .ev_stuff (ev_stuff),
    .ev_form  (ev_form),
    .ev_crc   (ev_crc),
    .ev_ack   (ev_ack),
    .in_fast  (in_fast),
    .in_tdc   (in_tdc),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data)
);

// File: tb/canfd_err_status_bench.sv
`timescale 1ns/1ps
module canfd_err_status_bench;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_bit = 0, ev_stuff = 0, ev_form = 0, ev_crc = 0, ev_ack = 0;
    logic in_fast = 0, in_tdc = 0, fixed_stuff = 0, crc_delim_bad = 0;
    logic wr_en = 0;
    logic [11:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit done = 0;

    always #5 clk = ~clk;

    canfd_err_status #(.DW(DW)) u_canfd_err_status (
        .clk(clk), .rst(rst), .ev_bit(ev_bit), .ev_stuff(ev_stuff),
        .ev_form(ev_form), .ev_crc(ev_crc), .ev_ack(ev_ack),
        .in_fast(in_fast), .in_tdc(in_tdc), .fixed_stuff(fixed_stuff),
        .crc_delim_bad(crc_delim_bad), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data)
    );

    // Behavioural reference: which flag bits this cycle's strobes set.
    function automatic int ref_set();
        int s = 0;
        int base;
        if (in_tdc) begin
            if (ev_bit || ev_stuff || ev_form || ev_crc || ev_ack) s = 1 << 11;
            return s;
        end
        base = in_fast ? 8 : 0;
        if (ev_ack) s |= 1 << 4;
        if (ev_bit) s |= 1 << (base + 3);
        if (ev_form) s |= 1 << (base + 1);
        if (ev_stuff) begin
            if (fixed_stuff) s |= 1 << (base + 1);
            else             s |= 1 << (base + 2);
        end
        if (ev_crc) begin
            if (crc_delim_bad) s |= 1 << (base + 1);
            else               s |= 1 << base;
        end
        return s;
    endfunction

    task automatic check(string req, int expv);
        checks++;
        if (rd_data !== DW'(expv)) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, rd_data, DW'(expv));
        end
    endtask

    task automatic idle_inputs();
        ev_bit = 0; ev_stuff = 0; ev_form = 0; ev_crc = 0; ev_ack = 0;
        in_fast = 0; in_tdc = 0; fixed_stuff = 0; crc_delim_bad = 0;
        wr_en = 0; wr_data = '0;
    endtask

    // Inputs are already driven (at a negedge); advance one edge and compare.
    task automatic step(string req);
        int clr;
        clr = wr_en ? int'(wr_data) : 0;
        model = ((model & ~clr) | ref_set()) & 'hF1F;
        @(posedge clk);
        @(negedge clk);
        check(req, model);
        idle_inputs();
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic [15:0] lfsr;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", 0);
        rst = 0;

        ev_crc = 1; step("R1");
        ev_form = 1; step("R1");
        ev_stuff = 1; step("R1");
        ev_bit = 1; step("R1");
        ev_ack = 1; step("R11");
        step("R3");
        step("R12");
        wr_en = 1; wr_data = 12'h0E0; step("R1");
        wr_en = 1; wr_data = 12'h000; step("R4");
        wr_en = 1; wr_data = 12'h005; step("R4");
        wr_en = 1; wr_data = 12'hFFF; step("R4");

        in_fast = 1; ev_bit = 1; step("R6");
        in_fast = 1; ev_stuff = 1; step("R6");
        in_fast = 1; ev_form = 1; step("R6");
        in_fast = 1; ev_crc = 1; step("R6");
        in_fast = 1; ev_ack = 1; step("R11");
        wr_en = 1; wr_data = 12'hFFF; step("R4");

        in_tdc = 1; ev_stuff = 1; ev_crc = 1; step("R7");
        wr_en = 1; wr_data = 12'hFFF; step("R4");
        in_tdc = 1; in_fast = 1; ev_ack = 1; step("R7");
        wr_en = 1; wr_data = 12'hFFF; step("R4");

        ev_stuff = 1; fixed_stuff = 1; step("R8");
        in_fast = 1; ev_stuff = 1; fixed_stuff = 1; step("R8");
        wr_en = 1; wr_data = 12'hFFF; step("R4");
        ev_crc = 1; crc_delim_bad = 1; step("R9");
        in_fast = 1; ev_crc = 1; crc_delim_bad = 1; step("R9");
        wr_en = 1; wr_data = 12'hFFF; step("R4");

        ev_bit = 1; ev_stuff = 1; ev_form = 1; ev_crc = 1; ev_ack = 1; step("R5");
        in_fast = 1; ev_bit = 1; ev_crc = 1; step("R5");

        ev_ack = 1; wr_en = 1; wr_data = 12'h010; step("R10");
        in_fast = 1; ev_bit = 1; wr_en = 1; wr_data = 12'h800; step("R10");

        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ev_bit = lfsr[0] & lfsr[5];
            ev_stuff = lfsr[1] & lfsr[6];
            ev_form = lfsr[2] & lfsr[7];
            ev_crc = lfsr[3] & lfsr[8];
            ev_ack = lfsr[4] & lfsr[9];
            in_fast = lfsr[10];
            in_tdc = lfsr[11] & lfsr[12] & lfsr[13];
            fixed_stuff = lfsr[12];
            crc_delim_bad = lfsr[14];
            wr_en = lfsr[15] & lfsr[3];
            wr_data = {lfsr[11:0]} ^ {lfsr[15:4]};
            step("R5");
        end

        rst = 1;
        @(posedge clk);
        @(negedge clk);
        model = 0;
        check("R2", 0);
        done = 1;
        report();
    end
endmodule